// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-wide MPEG transport stream, one byte per clock qualified by a valid strobe. A marker flags the first byte of each 188-byte packet, and an error sideband travels with the bytes. Each packet carries a 13-bit packet identifier (PID) in its header. The block compares that PID against a table of programmable slots, each with its own enable bit. It then forwards or discards the whole packet. Forwarded bytes leave after a constant delay of three clocks, so every packet on the output is complete.

A byte-addressed write/read port programs the block. It holds a control byte, a bank of enable bytes and a pair of bytes per PID slot. Control bits select four things: master enable, rejection of damaged packets, PID filtering on or off, and whether a slot hit keeps or discards the packet. Software may write at any moment. The filter captures the whole configuration when a packet begins, so each packet is judged under one setting.

The three header bytes of a packet (sync byte and the two PID-carrying bytes) must arrive on consecutive clocks. Idle cycles may fall anywhere after them and between packets.

Top module: `ts_pid_gate`

## Requirements
- R1: There are 32 PID slots of 13 bits. Slot n lives at byte addresses 0x26+2n (even address: PID bits 12:8 in data bits 4:0) and 0x27+2n (odd address: PID bits 7:0). Reads return the stored value, and unused upper bits read as zero.
- R2: The control byte is at 0x21. Only bits 7, 6, 5 and 3 are stored, and the others read as zero. Enable bytes sit at 0x22..0x25, where bit b of byte k (address 0x22+k) enables slot 8k+b. Any other address reads zero and ignores writes.
- R3: While control bit 3 (master enable) is clear, no packet is forwarded.
- R4: While control bit 7 (filtering) is clear, every packet is forwarded, subject only to R7.
- R5: With bit 7 set and bit 6 clear, a packet passes only if its PID equals the value of a slot whose enable bit is set. A slot whose enable bit is clear never matches.
- R6: With bits 7 and 6 set, a packet that matches an enabled slot is discarded and every other packet passes.
- R7: A packet counts as damaged if the error sideband is high on any of its first three bytes, or if bit 7 of header byte 1 is set. The PID is bits 4:0 of byte 1 followed by byte 2. With bit 5 set, damaged packets are discarded. With bit 5 clear they are judged by R3 to R6 alone.
- R8: A forwarded byte appears on the output exactly three clocks after it was presented, with unchanged data. The output start flag is high on the packet's first byte, and packets are forwarded or discarded whole.
- R9: Configuration is captured on the clock of each packet's first byte. A write during a packet affects only later packets.
- R10: During and right after reset the output valid is low, and every register reads zero.
- R11: Bytes that arrive before the first packet start are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address (write and read) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | 8 | Input stream byte |
| in_start | input | 1 | High on the first byte of a packet |
| in_err | input | 1 | Error sideband for the current byte |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Output stream byte (zero when not valid) |
| out_start | output | 1 | High on the first forwarded byte of a packet |

## Verification
The bench builds the block with its default parameters: 32 slots of 13 bits and an 8-bit address. This puts the last slot pair at 0x64/0x65 and the highest bit of the fourth enable byte within reach. Slots at both ends of the table are hit, as is a programmed but disabled slot. The masking of the five-bit upper PID field is checked on readback. Writes that change the configuration in the middle of a packet show that the captured setting holds to the packet's end.

// File: rtl/ts_pid_pkg.sv
package ts_pid_pkg;

  // Register map anchors (byte addresses)
  localparam int CTRL_ADDR = 'h21;
  localparam int MASK_ADDR = 'h22;
  localparam int SLOT_ADDR = 'h26;

  // Control byte bit positions
  localparam int CB_EN      = 3;
  localparam int CB_ERR_REJ = 5;
  localparam int CB_INV     = 6;
  localparam int CB_FILT    = 7;

  // Header bytes needed before a verdict exists; equals the stream delay
  localparam int HDR_BYTES = 3;

  typedef struct packed {
    logic filt;
    logic inv;
    logic err_rej;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/ts_rst_sync.sv
module ts_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match #(
  parameter int NUM_SLOTS = 32,
  parameter int PID_W     = 13
) (
  input  logic [PID_W-1:0]                pid,
  input  logic [NUM_SLOTS-1:0]            mask,
  input  logic [NUM_SLOTS-1:0][PID_W-1:0] tab,
  output logic                            hit
);

  logic [NUM_SLOTS-1:0] slot_eq;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_cmp
    assign slot_eq[n] = mask[n] && (tab[n] == pid);
  end

  assign hit = |slot_eq;

endmodule

// File: rtl/ts_pkt_judge.sv
module ts_pkt_judge
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int PID_W     = 13
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic                            in_start,
  input  logic                            in_err,
  input  logic [7:0]                      in_data,
  input  ctrl_t                           live_ctrl,
  input  logic [NUM_SLOTS-1:0]            live_mask,
  input  logic [NUM_SLOTS-1:0][PID_W-1:0] live_tab,
  output logic                            fwd
);

  localparam int HI_W = PID_W - 8;

  typedef enum logic [1:0] {
    H_IDLE,
    H_B1,
    H_B2
  } hpos_e;

  hpos_e                           pos_q, pos_d;
  logic                            err_q, err_d;
  logic [HI_W-1:0]                 hi_q, hi_d;
  logic                            fwd_q, fwd_d;
  ctrl_t                           sctl_q;
  logic [NUM_SLOTS-1:0]            smask_q;
  logic [NUM_SLOTS-1:0][PID_W-1:0] stab_q;

  logic                            snap_en;
  logic [PID_W-1:0]                pid_cur;
  logic                            err_cur;
  logic                            hit;
  logic                            pid_ok;

  assign snap_en = in_valid && in_start;
  assign pid_cur = {hi_q, in_data};
  assign err_cur = err_q || in_err;

  ts_pid_match #(
    .NUM_SLOTS(NUM_SLOTS),
    .PID_W    (PID_W)
  ) u_match (
    .pid (pid_cur),
    .mask(smask_q),
    .tab (stab_q),
    .hit (hit)
  );

  assign pid_ok = !sctl_q.filt || (hit ^ sctl_q.inv);

  // Next-state logic for header walk and verdict
  always_comb begin
    pos_d = pos_q;
    err_d = err_q;
    hi_d  = hi_q;
    fwd_d = fwd_q;
    if (in_valid) begin
      if (in_start) begin
        pos_d = H_B1;
        err_d = in_err;
      end else begin
        unique case (pos_q)
          H_B1: begin
            pos_d = H_B2;
            hi_d  = in_data[HI_W-1:0];
            err_d = err_q || in_err || in_data[7];
          end
          H_B2: begin
            pos_d = H_IDLE;
            fwd_d = sctl_q.en && pid_ok && !(sctl_q.err_rej && err_cur);
          end
          default: ;
        endcase
      end
    end
  end

  // Header walk registers, clock-enabled by the byte strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= H_IDLE;
      err_q <= 1'b0;
      hi_q  <= '0;
    end else if (in_valid) begin
      pos_q <= pos_d;
      err_q <= err_d;
      hi_q  <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q <= 1'b0;
    end else begin
      fwd_q <= fwd_d;
    end
  end

  // Configuration capture at packet start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sctl_q  <= '0;
      smask_q <= '0;
      stab_q  <= '0;
    end else if (snap_en) begin
      sctl_q  <= live_ctrl;
      smask_q <= live_mask;
      stab_q  <= live_tab;
    end
  end

  assign fwd = fwd_q;

endmodule

// File: rtl/ts_delay_line.sv
module ts_delay_line #(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_start,
  output logic [DATA_W-1:0] out_data
);

  logic [DEPTH-1:0]             v_q, v_d;
  logic [DEPTH-1:0]             s_q, s_d;
  logic [DEPTH-1:0][DATA_W-1:0] d_q, d_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign v_d[i] = in_valid;
      assign s_d[i] = in_valid && in_start;
      assign d_d[i] = in_data;
    end else begin : g_tail
      assign v_d[i] = v_q[i-1];
      assign s_d[i] = s_q[i-1];
      assign d_d[i] = d_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      s_q <= '0;
    end else begin
      v_q <= v_d;
      s_q <= s_d;
    end
  end

  // Data path without reset; qualified by the valid bits
  always_ff @(posedge clk) begin
    d_q <= d_d;
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_start = s_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];

endmodule

// File: rtl/ts_cfg_regs.sv
module ts_cfg_regs
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int PID_W     = 13,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [7:0]                      wdata,
  output logic [7:0]                      rdata,
  output ctrl_t                           ctrl,
  output logic [NUM_SLOTS-1:0]            mask,
  output logic [NUM_SLOTS-1:0][PID_W-1:0] tab
);

  localparam int MASK_BYTES = (NUM_SLOTS + 7) / 8;
  localparam int MASK_W     = MASK_BYTES * 8;
  localparam int HI_W       = PID_W - 8;

  ctrl_t                           ctrl_q, ctrl_d;
  logic [MASK_W-1:0]               mask_q, mask_d;
  logic [NUM_SLOTS-1:0][PID_W-1:0] tab_q, tab_d;
  int                              a_int;

  assign a_int = int'(addr);

  // Write decode
  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    tab_d  = tab_q;
    if (a_int == CTRL_ADDR) begin
      ctrl_d.filt    = wdata[CB_FILT];
      ctrl_d.inv     = wdata[CB_INV];
      ctrl_d.err_rej = wdata[CB_ERR_REJ];
      ctrl_d.en      = wdata[CB_EN];
    end
    for (int k = 0; k < MASK_BYTES; k++) begin
      if (a_int == MASK_ADDR + k) begin
        mask_d[8*k +: 8] = wdata;
      end
    end
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (a_int == SLOT_ADDR + 2*n) begin
        tab_d[n][PID_W-1:8] = wdata[HI_W-1:0];
      end
      if (a_int == SLOT_ADDR + 2*n + 1) begin
        tab_d[n][7:0] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      tab_q  <= '0;
    end else if (we) begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      tab_q  <= tab_d;
    end
  end

  // Read decode
  always_comb begin
    rdata = '0;
    if (a_int == CTRL_ADDR) begin
      rdata[CB_FILT]    = ctrl_q.filt;
      rdata[CB_INV]     = ctrl_q.inv;
      rdata[CB_ERR_REJ] = ctrl_q.err_rej;
      rdata[CB_EN]      = ctrl_q.en;
    end
    for (int k = 0; k < MASK_BYTES; k++) begin
      if (a_int == MASK_ADDR + k) begin
        rdata = mask_q[8*k +: 8];
      end
    end
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (a_int == SLOT_ADDR + 2*n) begin
        rdata = {{(16-PID_W){1'b0}}, tab_q[n][PID_W-1:8]};
      end
      if (a_int == SLOT_ADDR + 2*n + 1) begin
        rdata = tab_q[n][7:0];
      end
    end
  end

  assign ctrl = ctrl_q;
  assign mask = mask_q[NUM_SLOTS-1:0];
  assign tab  = tab_q;

endmodule

// File: rtl/ts_pid_gate.sv
module ts_pid_gate
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int PID_W     = 13,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_start,
  input  logic              in_err,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_start
);

  logic                            rst_sync_n;
  ctrl_t                           live_ctrl;
  logic [NUM_SLOTS-1:0]            live_mask;
  logic [NUM_SLOTS-1:0][PID_W-1:0] live_tab;
  logic                            fwd;
  logic                            dl_valid;
  logic                            dl_start;
  logic [7:0]                      dl_data;

  ts_rst_sync u_rst (
    .clk   (clk),
    .rst_ni(rst_n),
    .rst_no(rst_sync_n)
  );

  ts_cfg_regs #(
    .NUM_SLOTS(NUM_SLOTS),
    .PID_W    (PID_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .rdata(cfg_rdata),
    .ctrl (live_ctrl),
    .mask (live_mask),
    .tab  (live_tab)
  );

  ts_pkt_judge #(
    .NUM_SLOTS(NUM_SLOTS),
    .PID_W    (PID_W)
  ) u_judge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_err   (in_err),
    .in_data  (in_data),
    .live_ctrl(live_ctrl),
    .live_mask(live_mask),
    .live_tab (live_tab),
    .fwd      (fwd)
  );

  ts_delay_line #(
    .DEPTH (HDR_BYTES),
    .DATA_W(8)
  ) u_dly (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_data  (in_data),
    .out_valid(dl_valid),
    .out_start(dl_start),
    .out_data (dl_data)
  );

  assign out_valid = dl_valid && fwd;
  assign out_start = dl_start && fwd;
  assign out_data  = out_valid ? dl_data : 8'h00;

endmodule

// File: rtl/ts_pid_gate_chk.sv
module ts_pid_gate_chk
  import ts_pid_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int PID_W     = 13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_rdata,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_start,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_start
);

  a_r8_fixed_delay_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  a_r8_fixed_delay_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == $past(in_data, 3)));

  a_r8_start_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> (out_valid && $past(in_start, 3)));

  a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(cfg_addr) == 8'(CTRL_ADDR) && !cfg_we
      && cfg_addr == 8'(CTRL_ADDR))
    |-> (cfg_rdata == ($past(cfg_wdata) & 8'hE8)));

  a_r1_slot_hi_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && !cfg_we && cfg_addr == $past(cfg_addr)
      && int'(cfg_addr) >= SLOT_ADDR && int'(cfg_addr) < SLOT_ADDR + 2*NUM_SLOTS
      && !cfg_addr[0])
    |-> (cfg_rdata == {{(16-PID_W){1'b0}}, $past(cfg_wdata[PID_W-9:0])}));

  a_r10_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

endmodule

bind ts_pid_gate ts_pid_gate_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .PID_W    (PID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_start (in_start),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_start(out_start)
);

// File: tb/sim_ts_pid_gate.sv
module sim_ts_pid_gate;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 32;
  localparam int PKT_LEN    = 188;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_start;
  logic       in_err;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_start;

  ts_pid_gate u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_start (in_start),
    .in_err   (in_err),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_start(out_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests;
  int fails;
  int ncyc;

  // Bench model of the register file
  logic [7:0]  m_ctrl;
  logic [31:0] m_mask;
  logic [12:0] m_pid [NSLOT];

  // Ring of presented bytes with their expected fate
  logic       r_v [8];
  logic [7:0] r_d [8];
  logic       r_s [8];
  logic       r_p [8];
  string      r_t [8];

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int ai;
    ai = int'(a);
    if (ai == 'h21) return m_ctrl & 8'hE8;
    if (ai >= 'h22 && ai <= 'h25) return m_mask[8*(ai-'h22) +: 8];
    if (ai >= 'h26 && ai <= 'h65) begin
      if (ai[0] == 1'b0) return {3'b000, m_pid[(ai-'h26)/2][12:8]};
      return m_pid[(ai-'h26)/2][7:0];
    end
    return 8'h00;
  endfunction

  function automatic logic ref_pass(input logic [12:0] pid, input logic damaged);
    logic hit;
    logic pid_ok;
    hit = 1'b0;
    for (int n = 0; n < NSLOT; n++) begin
      if (m_mask[n] && m_pid[n] == pid) hit = 1'b1;
    end
    if (!m_ctrl[7]) pid_ok = 1'b1;
    else if (m_ctrl[6]) pid_ok = !hit;
    else pid_ok = hit;
    return m_ctrl[3] && pid_ok && !(m_ctrl[5] && damaged);
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
    int ai;
    ai = int'(a);
    if (ai == 'h21) m_ctrl = d & 8'hE8;
    else if (ai >= 'h22 && ai <= 'h25) m_mask[8*(ai-'h22) +: 8] = d;
    else if (ai >= 'h26 && ai <= 'h65) begin
      if (ai[0] == 1'b0) m_pid[(ai-'h26)/2][12:8] = d[4:0];
      else m_pid[(ai-'h26)/2][7:0] = d;
    end
  endfunction

  // One clock: drive, then check the output against the byte from 3 cycles back
  task automatic step(input logic v, input logic [7:0] d, input logic s,
                      input logic e, input logic p, input string tag);
    begin
      int  j;
      logic ev;
      in_valid = v;
      in_data  = d;
      in_start = s;
      in_err   = e;
      r_v[ncyc % 8] = v;
      r_d[ncyc % 8] = d;
      r_s[ncyc % 8] = s;
      r_p[ncyc % 8] = p;
      r_t[ncyc % 8] = tag;
      @(posedge clk);
      @(negedge clk);
      if (ncyc >= 2) begin
        j  = (ncyc - 2) % 8;
        ev = r_v[j] && r_p[j];
        tests++;
        if (out_valid !== ev || (ev && (out_data !== r_d[j] || out_start !== r_s[j]))) begin
          fails++;
          $display("FAIL %s: out valid/data/start=%b/%h/%b expected %b/%h/%b",
                   r_t[j], out_valid, out_data, out_start, ev, r_d[j], r_s[j] && ev);
        end
      end
      ncyc++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "idle");
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "cfg");
    cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic reg_check(input logic [7:0] a, input string tag);
    logic [7:0] ex;
    cfg_addr = a;
    #1;
    ex = exp_rd(a);
    tests++;
    if (cfg_rdata !== ex) begin
      fails++;
      $display("FAIL %s: read addr %h got %h expected %h", tag, a, cfg_rdata, ex);
    end
  endtask

  task automatic write_slot(input int n, input logic [12:0] v);
    reg_write(8'('h26 + 2*n), {3'b000, v[12:8]});
    reg_write(8'('h27 + 2*n), v[7:0]);
  endtask

  // errpos: -1 none, 0..2 byte carrying the sideband error
  task automatic send_pkt(input logic [12:0] pid, input int errpos, input logic tei,
                          input string tag, input logic mid_wr,
                          input logic [7:0] wa, input logic [7:0] wd);
    logic p;
    logic [7:0] d;
    p = ref_pass(pid, (errpos >= 0) || tei);
    for (int i = 0; i < PKT_LEN; i++) begin
      if (i == 0) d = 8'h47;
      else if (i == 1) d = {tei, 2'($urandom), pid[12:8]};
      else if (i == 2) d = pid[7:0];
      else d = 8'($urandom);
      if (mid_wr && i == 50) begin
        cfg_we = 1'b1;
        cfg_addr = wa;
        cfg_wdata = wd;
      end
      step(1'b1, d, i == 0, i == errpos, p, tag);
      if (mid_wr && i == 50) begin
        cfg_we = 1'b0;
        model_write(wa, wd);
      end
    end
  endtask

  task automatic pkt(input logic [12:0] pid, input string tag);
    send_pkt(pid, -1, 1'b0, tag, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R8 watchdog: actual run still going, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    tests = 0;
    fails = 0;
    ncyc  = 0;
    m_ctrl = '0;
    m_mask = '0;
    for (int n = 0; n < NSLOT; n++) m_pid[n] = '0;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_addr = 8'h00;
    cfg_wdata = 8'h00;
    in_valid = 1'b0;
    in_data = 8'h00;
    in_start = 1'b0;
    in_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: quiet output and cleared registers
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    for (int a = 'h20; a <= 'h66; a++) reg_check(8'(a), "R10");
    idle(4);

    // R2: control masking, unmapped addresses
    reg_write(8'h21, 8'hFF);
    reg_check(8'h21, "R2");
    reg_write(8'h20, 8'h5A);
    reg_check(8'h20, "R2");
    reg_write(8'h66, 8'hA5);
    reg_check(8'h66, "R2");
    reg_write(8'h22, 8'h08);
    reg_write(8'h25, 8'h80);
    reg_check(8'h22, "R2");
    reg_check(8'h25, "R2");

    // R1: slots at both ends, upper bits masked
    reg_write(8'h2C, 8'hFA);
    reg_write(8'h2D, 8'hBC);
    reg_check(8'h2C, "R1");
    reg_check(8'h2D, "R1");
    write_slot(31, 13'h0123);
    write_slot(0, 13'h0100);
    reg_check(8'h64, "R1");
    reg_check(8'h65, "R1");
    reg_check(8'h26, "R1");

    // R11: stray bytes before any packet start
    reg_write(8'h21, 8'h08);
    for (int i = 0; i < 4; i++) step(1'b1, 8'($urandom), 1'b0, 1'b0, 1'b0, "R11");

    // R4: filtering off
    pkt(13'h0555, "R4");
    pkt(13'h1ABC, "R4");
    // R3: master enable off
    reg_write(8'h21, 8'h80);
    pkt(13'h1ABC, "R3");
    reg_write(8'h21, 8'h00);
    pkt(13'h0555, "R3");
    // R5: keep on hit; slot 0 programmed but disabled
    reg_write(8'h21, 8'h88);
    pkt(13'h1ABC, "R5");
    pkt(13'h0123, "R5");
    pkt(13'h0100, "R5");
    pkt(13'h0777, "R5");
    // R6: discard on hit
    reg_write(8'h21, 8'hC8);
    pkt(13'h1ABC, "R6");
    pkt(13'h0100, "R6");
    pkt(13'h0777, "R6");
    // R7: damaged packets
    reg_write(8'h21, 8'h28);
    send_pkt(13'h0555, 0, 1'b0, "R7", 1'b0, 8'h00, 8'h00);
    send_pkt(13'h0555, 1, 1'b0, "R7", 1'b0, 8'h00, 8'h00);
    send_pkt(13'h0555, 2, 1'b0, "R7", 1'b0, 8'h00, 8'h00);
    send_pkt(13'h0555, -1, 1'b1, "R7", 1'b0, 8'h00, 8'h00);
    pkt(13'h0555, "R7");
    reg_write(8'h21, 8'h08);
    send_pkt(13'h0555, 1, 1'b0, "R7", 1'b0, 8'h00, 8'h00);
    send_pkt(13'h0555, -1, 1'b1, "R7", 1'b0, 8'h00, 8'h00);
    reg_write(8'h21, 8'hA8);
    send_pkt(13'h1ABC, 2, 1'b0, "R7", 1'b0, 8'h00, 8'h00);
    // R9: mid-packet writes take effect on the next packet
    reg_write(8'h21, 8'h08);
    send_pkt(13'h0555, -1, 1'b0, "R9", 1'b1, 8'h21, 8'h00);
    send_pkt(13'h0555, -1, 1'b0, "R9", 1'b1, 8'h21, 8'h08);
    pkt(13'h0555, "R9");
    idle(2);

    // Random phase
    for (int it = 0; it < 40; it++) begin
      int sel;
      int ep;
      logic [12:0] pid;
      if ($urandom % 4 == 0) reg_write(8'h21, 8'($urandom) | (($urandom % 5 != 0) ? 8'h08 : 8'h00));
      if ($urandom % 4 == 0) reg_write(8'('h22 + $urandom % 4), 8'($urandom));
      if ($urandom % 4 == 0) write_slot(int'($urandom % NSLOT), 13'($urandom));
      sel = int'($urandom % NSLOT);
      pid = ($urandom % 2 == 0) ? m_pid[sel] : 13'($urandom);
      ep  = ($urandom % 6 == 0) ? int'($urandom % 3) : -1;
      send_pkt(pid, ep, ($urandom % 8 == 0), "R5/R6/R7 random", 1'b0, 8'h00, 8'h00);
      idle(int'($urandom % 3));
    end
    idle(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule